// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Registers

This block is the software-facing register file of a four-channel DMA controller. Each channel has a source address, a destination address, a transfer count and a control word. A single operation word gates the whole controller. The data movement itself happens elsewhere. The transfer engine reports that a channel has completed with a one-cycle pulse. The block records that pulse in the channel's transfer-end flag.

Each channel drives its own interrupt line. The line is high while the channel's interrupt-enable and transfer-end bits are both set. Software acknowledges an interrupt by writing a control word in which either of those bits is zero, and the line drops on the next cycle. The block also produces three qualified status outputs:

- a global enable, taken from an exact pattern in the operation word;
- a per-channel run-permission output;
- a per-channel auto-request flag, decoded from the channel's resource-select field.

Register map (32-bit words, byte addresses):

- Channel `n` occupies the block at `n*0x10`. Within that block, offset 0x0 is the source address, 0x4 the destination address, 0x8 the count and 0xC the control word.
- The operation word sits at 0x40.

Top module: `dmacr_regs`

## Requirements
- R1: After synchronous reset, every register reads zero, and `irq`, `dma_on`, `ch_run`, `auto_req` and `rdata` are all zero.
- R2: The four registers of channel `n` are at byte addresses `n*0x10 + {0x0 source, 0x4 destination, 0x8 count, 0xC control}`. `rdata` is registered: it shows the word addressed in the previous cycle, with the value it held before any write made in that same cycle.
- R3: The count register keeps only bits [23:0]. The control and operation registers keep only bits [15:0]. Bits above these read back as zero.
- R4: `dma_on` is high exactly when bits [2:0] of the operation register equal 3'b001. It follows a write to address 0x40 on the next cycle.
- R5: `irq[n]` is high exactly when control bit 2 (interrupt enable) and bit 1 (transfer end) of channel `n` are both set. A control write with either bit zero, and no completion pulse in that cycle, drops the line on the next cycle.
- R6: A pulse on `xfer_done[n]` sets control bit 1 of channel `n` on the next cycle. The pulse wins over a software write of zero to that bit in the same cycle; the other bits of that write still take effect.
- R7: `ch_run[n]` is high exactly when `dma_on` is high, control bit 0 (channel enable) is set and control bit 1 is clear.
- R8: `auto_req[n]` is high exactly when control bits [11:10] of channel `n` equal 2'b01.
- R9: An address with bits [1:0] not zero, an address in the 0x40 block other than 0x40, or an address at 0x50 or above is unmapped. Writes to it change nothing, and reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 8 | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| xfer_done | input | 4 | Per-channel completion pulse from the transfer engine |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 4 | Per-channel interrupt lines |
| dma_on | output | 1 | Global enable decoded from the operation register |
| ch_run | output | 4 | Per-channel permission to run |
| auto_req | output | 4 | Per-channel auto-request flag from the resource select |

## Verification
The assertions assume that `addr`, `wdata`, `wr_en` and `xfer_done` are stable around each rising edge and carry no unknown values once reset is released. They also assume that a completion pulse may arrive in the same cycle as any register write, including one to that channel's control word. The stimulus keeps within this: it drives every input from the falling edge, and in the random phase it mixes mapped and unmapped addresses with independent completion pulses on all channels.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

  // control word bit positions
  localparam int CTL_EN   = 0;
  localparam int CTL_END  = 1;
  localparam int CTL_IEN  = 2;
  localparam int RSEL_HI  = 11;
  localparam int RSEL_LO  = 10;

  // pattern in RSEL_HI:RSEL_LO marking an auto-request channel
  localparam logic [1:0] AUTO_PATTERN = 2'b01;

  // the only operation-word pattern that enables the controller
  localparam logic [2:0] RUN_PATTERN = 3'b001;

  // byte span of one channel's register block
  localparam int BLOCK_SHIFT = 4;

  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CNT = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/dmacr_decode.sv
module dmacr_decode
  import dmacr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ch_hit,
  output logic [IDX_W-1:0]  ch_idx,
  output reg_sel_e          sel,
  output logic              op_hit
);

  localparam int BLK_W = ADDR_W - BLOCK_SHIFT;

  logic [BLK_W-1:0] blk;
  logic             aligned;

  always_comb begin
    blk     = addr[ADDR_W-1:BLOCK_SHIFT];
    aligned = (addr[1:0] == 2'b00);
    ch_hit  = aligned && (blk < BLK_W'(NUM_CH));
    op_hit  = aligned && (blk == BLK_W'(NUM_CH)) && (addr[3:2] == 2'b00);
    ch_idx  = blk[IDX_W-1:0];
    sel     = reg_sel_e'(addr[3:2]);
  end

endmodule

// File: rtl/dmacr_store.sv
module dmacr_store
  import dmacr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 24,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0]  src_q [NUM_CH];
  logic [DATA_W-1:0]  dst_q [NUM_CH];
  logic [COUNT_W-1:0] cnt_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (wr) begin
      case (sel)
        SEL_SRC: src_q[idx] <= wdata;
        SEL_DST: dst_q[idx] <= wdata;
        SEL_CNT: cnt_q[idx] <= wdata[COUNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_SRC: rd_word = src_q[idx];
      SEL_DST: rd_word = dst_q[idx];
      SEL_CNT: rd_word = {{(DATA_W-COUNT_W){1'b0}}, cnt_q[idx]};
      default: rd_word = '0;
    endcase
  end

endmodule

// File: rtl/dmacr_chan.sv
module dmacr_chan
  import dmacr_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [CTRL_W-1:0] ctl_wdata,
  input  logic              done,
  input  logic              glob_on_nxt,
  output logic [CTRL_W-1:0] ctl_q,
  output logic              irq_q,
  output logic              run_q,
  output logic              auto_q
);

  logic [CTRL_W-1:0] ctl_nxt;

  // a completion pulse overrides a software write of the end flag
  always_comb begin
    ctl_nxt = ctl_wr ? ctl_wdata : ctl_q;
    if (done) ctl_nxt[CTL_END] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      irq_q  <= 1'b0;
      run_q  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_nxt;
      irq_q  <= ctl_nxt[CTL_IEN] & ctl_nxt[CTL_END];
      run_q  <= glob_on_nxt & ctl_nxt[CTL_EN] & ~ctl_nxt[CTL_END];
      auto_q <= (ctl_nxt[RSEL_HI:RSEL_LO] == AUTO_PATTERN);
    end
  end

endmodule

// File: rtl/dmacr_global.sv
module dmacr_global
  import dmacr_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_wr,
  input  logic [OP_W-1:0] op_wdata,
  output logic [OP_W-1:0] op_q,
  output logic            on_q,
  output logic            on_nxt
);

  logic [OP_W-1:0] op_nxt;

  always_comb begin
    op_nxt = op_wr ? op_wdata : op_q;
    on_nxt = (op_nxt[2:0] == RUN_PATTERN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0;
      on_q <= 1'b0;
    end else begin
      op_q <= op_nxt;
      on_q <= on_nxt;
    end
  end

endmodule

// File: rtl/dmacr_regs.sv
module dmacr_regs
  import dmacr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 24,
  parameter int CTRL_W  = 16,
  parameter int OP_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              dma_on,
  output logic [NUM_CH-1:0] ch_run,
  output logic [NUM_CH-1:0] auto_req
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic             ch_hit;
  logic             op_hit;
  logic [IDX_W-1:0] ch_idx;
  reg_sel_e         sel;
  logic [DATA_W-1:0] store_rd;
  logic [OP_W-1:0]   op_q;
  logic              on_nxt;
  logic [CTRL_W-1:0] ctl_arr [NUM_CH];
  logic [DATA_W-1:0] rd_nxt;
  logic [DATA_W-1:0] rdata_q;

  dmacr_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .ch_hit(ch_hit), .ch_idx(ch_idx), .sel(sel), .op_hit(op_hit)
  );

  dmacr_store #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .COUNT_W(COUNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr(wr_en && ch_hit && (sel != SEL_CTL)),
    .idx(ch_idx), .sel(sel), .wdata(wdata), .rd_word(store_rd)
  );

  dmacr_global #(
    .OP_W(OP_W)
  ) u_glob (
    .clk(clk), .rst(rst), .op_wr(wr_en && op_hit),
    .op_wdata(wdata[OP_W-1:0]), .op_q(op_q), .on_q(dma_on), .on_nxt(on_nxt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ctl_wr_g;
    assign ctl_wr_g = wr_en && ch_hit && (sel == SEL_CTL) && (ch_idx == IDX_W'(g));

    dmacr_chan #(
      .CTRL_W(CTRL_W)
    ) u_chan (
      .clk(clk), .rst(rst), .ctl_wr(ctl_wr_g), .ctl_wdata(wdata[CTRL_W-1:0]),
      .done(xfer_done[g]), .glob_on_nxt(on_nxt), .ctl_q(ctl_arr[g]),
      .irq_q(irq[g]), .run_q(ch_run[g]), .auto_q(auto_req[g])
    );
  end

  always_comb begin
    if (ch_hit && sel == SEL_CTL)
      rd_nxt = {{(DATA_W-CTRL_W){1'b0}}, ctl_arr[ch_idx]};
    else if (ch_hit)
      rd_nxt = store_rd;
    else if (op_hit)
      rd_nxt = {{(DATA_W-OP_W){1'b0}}, op_q};
    else
      rd_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/dmacr_regs_chk.sv
module dmacr_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NUM_CH-1:0] xfer_done,
  input logic [DATA_W-1:0] rdata,
  input logic [NUM_CH-1:0] irq,
  input logic              dma_on,
  input logic [NUM_CH-1:0] ch_run,
  input logic [NUM_CH-1:0] auto_req
);

  localparam logic [ADDR_W-1:0] OP_A = ADDR_W'(NUM_CH * 16);

  AST_OP_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OP_A) |=> (dma_on == ($past(wdata[2:0]) == 3'b001))); // R4

  AST_UNALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr[1:0] != 2'b00) |=> (rdata == '0)); // R9

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(g * 16 + 12);

    AST_IRQ_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == CTL_A && !(wdata[1] && wdata[2]) && !xfer_done[g])
        |=> !irq[g]); // R5

    AST_IRQ_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !xfer_done[g]) |=> $stable(irq[g])); // R5

    AST_DONE_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
      xfer_done[g] |=> !ch_run[g]); // R6

    AST_RUN_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
      ch_run[g] |-> dma_on); // R7

    AST_AUTO_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == CTL_A) |=> (auto_req[g] == ($past(wdata[11:10]) == 2'b01))); // R8
  end

endmodule

bind dmacr_regs dmacr_regs_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .xfer_done(xfer_done), .rdata(rdata), .irq(irq), .dma_on(dma_on),
  .ch_run(ch_run), .auto_req(auto_req)
);

// File: tb/dmacr_regs_test.sv
module dmacr_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [3:0]  xfer_done = '0;
  logic [31:0] rdata;
  logic [3:0]  irq, ch_run, auto_req;
  logic        dma_on;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmacr_regs uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .xfer_done(xfer_done), .rdata(rdata), .irq(irq), .dma_on(dma_on),
    .ch_run(ch_run), .auto_req(auto_req)
  );

  // behavioural reference state
  logic [31:0] m_src [NCH];
  logic [31:0] m_dst [NCH];
  logic [31:0] m_cnt [NCH];
  logic [31:0] m_ctl [NCH];
  logic [31:0] m_op;
  logic [31:0] m_rd;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int blk = int'(a[7:4]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (blk < NCH) begin
      case (a[3:2])
        2'd0: return m_src[blk];
        2'd1: return m_dst[blk];
        2'd2: return m_cnt[blk];
        default: return m_ctl[blk];
      endcase
    end
    if (blk == NCH && a[3:2] == 2'd0) return m_op;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0;
      end
      m_op = 0;
      m_rd = 0;
    end else begin
      logic [31:0] rd;
      int blk;
      rd = model_read(addr);
      blk = int'(addr[7:4]);
      if (wr_en && addr[1:0] == 2'b00) begin
        if (blk < NCH) begin
          case (addr[3:2])
            2'd0: m_src[blk] = wdata;
            2'd1: m_dst[blk] = wdata;
            2'd2: m_cnt[blk] = wdata & 32'h00FF_FFFF;
            default: m_ctl[blk] = wdata & 32'h0000_FFFF;
          endcase
        end else if (blk == NCH && addr[3:2] == 2'd0) begin
          m_op = wdata & 32'h0000_FFFF;
        end
      end
      for (int i = 0; i < NCH; i++)
        if (xfer_done[i]) m_ctl[i] = m_ctl[i] | 32'h2;
      m_rd = rd;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] e_irq, e_run, e_auto;
      logic e_on;
      e_on = (m_op[2:0] == 3'b001);
      for (int i = 0; i < NCH; i++) begin
        e_irq[i]  = m_ctl[i][2] & m_ctl[i][1];
        e_run[i]  = e_on & m_ctl[i][0] & ~m_ctl[i][1];
        e_auto[i] = (m_ctl[i][11:10] == 2'b01);
      end
      check(rdata == m_rd, "R2 rdata", rdata, m_rd);
      check(irq == e_irq, "R5 irq", {28'h0, irq}, {28'h0, e_irq});
      check(dma_on == e_on, "R4 dma_on", {31'h0, dma_on}, {31'h0, e_on});
      check(ch_run == e_run, "R7 ch_run", {28'h0, ch_run}, {28'h0, e_run});
      check(auto_req == e_auto, "R8 auto_req", {28'h0, auto_req}, {28'h0, e_auto});
    end
  end

  // called just after a falling edge; returns just after the next one
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] done);
    addr = a; wdata = d; wr_en = 1'b1; xfer_done = done;
    @(negedge clk);
    wr_en = 1'b0; xfer_done = '0;
  endtask

  task automatic pulse(input logic [3:0] done);
    xfer_done = done;
    @(negedge clk);
    xfer_done = '0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    check(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(irq == 0 && ch_run == 0 && auto_req == 0 && !dma_on, "R1 outputs",
          {27'h0, irq, dma_on}, 32'h0);
    rd_chk(8'h0C, 32'h0, "R1 ctl0");
    rd_chk(8'h38, 32'h0, "R1 cnt3");
    rd_chk(8'h40, 32'h0, "R1 op");

    // R2: register placement per channel
    for (int c = 0; c < NCH; c++) begin
      wr(8'(c*16 + 0), 32'hA000_0000 + 32'(c), '0);
      wr(8'(c*16 + 4), 32'hB000_0000 + 32'(c), '0);
    end
    for (int c = 0; c < NCH; c++) begin
      rd_chk(8'(c*16 + 0), 32'hA000_0000 + 32'(c), "R2 src");
      rd_chk(8'(c*16 + 4), 32'hB000_0000 + 32'(c), "R2 dst");
    end

    // R3: width truncation
    wr(8'h28, 32'hFFFF_FFFF, '0);
    rd_chk(8'h28, 32'h00FF_FFFF, "R3 count");
    wr(8'h3C, 32'hFFFF_F000, '0);
    rd_chk(8'h3C, 32'h0000_F000, "R3 ctl");

    // R4: exact enable pattern
    wr(8'h40, 32'h0000_0001, '0);
    check(dma_on == 1'b1, "R4 on", {31'h0, dma_on}, 32'h1);
    wr(8'h40, 32'h0000_0005, '0);
    check(dma_on == 1'b0, "R4 halt", {31'h0, dma_on}, 32'h0);
    wr(8'h40, 32'h0000_0003, '0);
    check(dma_on == 1'b0, "R4 error", {31'h0, dma_on}, 32'h0);
    wr(8'h40, 32'h0001_0009, '0);
    check(dma_on == 1'b1, "R4 upper bits", {31'h0, dma_on}, 32'h1);
    rd_chk(8'h40, 32'h0000_0009, "R3 op");

    // R7/R8: channel 1 enabled, auto request
    wr(8'h1C, 32'h0000_0405, '0);
    check(ch_run[1] && auto_req[1] && !irq[1], "R7 run",
          {28'h0, ch_run}, 32'h2);
    // R6: completion sets end flag
    pulse(4'b0010);
    check(irq[1] && !ch_run[1], "R6 done", {28'h0, irq}, 32'h2);
    rd_chk(8'h1C, 32'h0000_0407, "R6 ctl1");
    // R5: acknowledge by clearing end flag
    wr(8'h1C, 32'h0000_0405, '0);
    check(!irq[1] && ch_run[1], "R5 ack end", {28'h0, irq}, 32'h0);
    pulse(4'b0010);
    wr(8'h1C, 32'h0000_0003, '0);
    check(!irq[1], "R5 ack enable", {28'h0, irq}, 32'h0);

    // R6: completion beats simultaneous write of zero
    wr(8'h2C, 32'h0000_0005, 4'b0100);
    check(irq[2] && !ch_run[2], "R6 priority", {28'h0, irq}, 32'h4);
    rd_chk(8'h2C, 32'h0000_0007, "R6 priority ctl2");

    // R9: unmapped addresses
    wr(8'h01, 32'hDEAD_BEEF, '0);
    rd_chk(8'h00, 32'hA000_0000, "R9 misaligned write");
    rd_chk(8'h01, 32'h0, "R9 misaligned read");
    wr(8'h44, 32'h1234_5678, '0);
    rd_chk(8'h44, 32'h0, "R9 gap read");
    wr(8'h50, 32'h1234_5678, '0);
    rd_chk(8'h50, 32'h0, "R9 beyond read");
    rd_chk(8'h40, 32'h0000_0009, "R9 op untouched");

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      int pick = int'($urandom_range(0, 19));
      if (pick < 16) a = 8'(pick * 4);
      else if (pick == 16) a = 8'h40;
      else a = 8'($urandom_range(0, 255));
      d = $urandom;
      if (pick == 16 && d[0]) d[2:0] = 3'b001;
      addr = a; wdata = d;
      wr_en = ($urandom_range(0, 2) != 0);
      xfer_done = 4'($urandom) & 4'($urandom) & 4'($urandom);
      @(negedge clk);
    end
    wr_en = 1'b0; xfer_done = '0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule